// File: doc/BRIEF.md
# Storage-Card Host Interrupt Unit

This block sits beside a memory-card host controller and turns its event and FIFO status into one interrupt request for an 8-bit CPU. The controller's command sequencer sends single-cycle pulses when a response has been received, when a command has gone out, and when a stream or block transfer has completed. The card busy line and the full and empty lines of the two data FIFOs come in as levels. The unit keeps each source as a bit in a flag register. A mask register decides which flags may raise the interrupt line.

Software sees two registers on a small synchronous bus. A read of the flag register returns the flags and clears the event-type flags (the three transfer events and card busy). FIFO flags behave differently. A full flag stays set until its FIFO next becomes empty, and an empty flag stays set until its FIFO next becomes full. Reads leave them alone, so the FIFO bits act as hysteretic status.

Top module: `sdc_irq_unit`

## Requirements
- R1: After reset the flag register reads 8'h03, the mask register reads 8'hFF, `irq` is 0 and `bus_rdata` is 0.
- R2: A pulse on `evt_pulse[2]` (response received), `evt_pulse[1]` (command sent) or `evt_pulse[0]` (transfer done) sets flag bit 6, 5 or 4 respectively, and the bit stays set until the flag register is read.
- R3: A read with `bus_rd`=1 and `bus_addr`=0 places the flag register on `bus_rdata` one cycle later and clears flag bits 7 to 4.
- R4: When an event pulse coincides with a flag-register read, the read returns the value from before the pulse and the pulsed bit stays set for the following read.
- R5: A rising edge of `card_busy` sets flag bit 7; while `card_busy` stays high no further set occurs after the bit is cleared by a read.
- R6: A rising edge of `fifo_full[0]` or `fifo_full[1]` sets flag bit 2 or bit 3; the bit survives reads and clears only on a rising edge of the same FIFO's `fifo_empty` line.
- R7: A rising edge of `fifo_empty[0]` or `fifo_empty[1]` sets flag bit 0 or bit 1; the bit survives reads and clears only on a rising edge of the same FIFO's `fifo_full` line.
- R8: The mask register at `bus_addr`=1 is written with `bus_wr` and read back unchanged one cycle after `bus_rd`; mask access has no effect on the flags.
- R9: `irq` is a register that, one cycle after any flag or mask update, equals the OR over all bits of (flag AND NOT mask); mask bit 1 blocks the matching flag.
- R10: A write to the flag register (`bus_addr`=0) is ignored and leaves the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_pulse | input | EVT_N | Single-cycle event pulses: [2] response received, [1] command sent, [0] transfer done |
| card_busy | input | 1 | Card busy level |
| fifo_full | input | FIFO_N | Full level per data FIFO ([0] is FIFO 1) |
| fifo_empty | input | FIFO_N | Empty level per data FIFO ([0] is FIFO 1) |
| bus_addr | input | ADDR_W | Register select: 0 flags, 1 mask |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | REG_W | Write data |
| bus_rdata | output | REG_W | Registered read data, held between reads |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench builds the unit with its default parameters: three event sources and two FIFOs, which gives the 8-bit register layout. With these values, every flag bit, the boundary between the event and FIFO fields, and the reset pattern 8'h03 can be checked at the bus. The cases covered are a read that coincides with an event, a busy line held high across reads, and the full-to-empty crossings of both FIFOs with a neutral state in between.

// File: rtl/sdc_irq_pkg.sv
`timescale 1ns/1ps
package sdc_irq_pkg;
  // register offsets on the local bus
  localparam int OFS_FLAGS = 0;
  localparam int OFS_MASK  = 1;
endpackage

// File: rtl/sdc_fifo_flags.sv
`timescale 1ns/1ps
module sdc_fifo_flags (
  input  logic clk,
  input  logic rst,
  input  logic full_in,
  input  logic empty_in,
  output logic full_flag,
  output logic empty_flag
);
  logic full_prev, empty_prev;
  logic full_rise, empty_rise;

  assign full_rise  = full_in  & ~full_prev;
  assign empty_rise = empty_in & ~empty_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      full_prev  <= 1'b0;
      empty_prev <= 1'b1;
      full_flag  <= 1'b0;
      empty_flag <= 1'b1;
    end else begin
      full_prev  <= full_in;
      empty_prev <= empty_in;
      if (full_rise)       full_flag <= 1'b1;
      else if (empty_rise) full_flag <= 1'b0;
      if (empty_rise)      empty_flag <= 1'b1;
      else if (full_rise)  empty_flag <= 1'b0;
    end
  end

  // R6
  full_set_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(full_flag) |-> $past(full_in));
  // R6
  full_clr_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(full_flag) |-> $past(empty_in));
  // R7
  empty_clr_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(empty_flag) |-> $past(full_in));
endmodule

// File: rtl/sdc_evt_flags.sv
`timescale 1ns/1ps
module sdc_evt_flags #(
  parameter int EVT_N = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [EVT_N-1:0] evt_pulse,
  input  logic             card_busy,
  input  logic             rd_clr,
  output logic [EVT_N-1:0] evt_flags,
  output logic             busy_flag
);
  logic busy_prev;

  for (genvar i = 0; i < EVT_N; i++) begin : g_evt
    always_ff @(posedge clk) begin
      if (rst) evt_flags[i] <= 1'b0;
      else     evt_flags[i] <= evt_pulse[i] | (evt_flags[i] & ~rd_clr);
    end

    // R2
    evt_set_chk: assert property (@(posedge clk) disable iff (rst)
      evt_pulse[i] |=> evt_flags[i]);
    // R3
    evt_clr_chk: assert property (@(posedge clk) disable iff (rst)
      (rd_clr && !evt_pulse[i]) |=> !evt_flags[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_prev <= 1'b0;
      busy_flag <= 1'b0;
    end else begin
      busy_prev <= card_busy;
      busy_flag <= (card_busy & ~busy_prev) | (busy_flag & ~rd_clr);
    end
  end

  // R5
  busy_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_clr && !card_busy) |=> !busy_flag);
endmodule

// File: rtl/sdc_mask_reg.sv
`timescale 1ns/1ps
module sdc_mask_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] mask
);
  always_ff @(posedge clk) begin
    if (rst)     mask <= '1;
    else if (wr) mask <= wdata;
  end

  // R8
  mask_wr_chk: assert property (@(posedge clk) disable iff (rst)
    wr |=> (mask == $past(wdata)));
endmodule

// File: rtl/sdc_irq_unit.sv
`timescale 1ns/1ps
module sdc_irq_unit
  import sdc_irq_pkg::*;
#(
  parameter int EVT_N  = 3,
  parameter int FIFO_N = 2,
  parameter int ADDR_W = 1,
  parameter int REG_W  = 1 + EVT_N + 2 * FIFO_N
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [EVT_N-1:0]  evt_pulse,
  input  logic              card_busy,
  input  logic [FIFO_N-1:0] fifo_full,
  input  logic [FIFO_N-1:0] fifo_empty,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_FLAGS = ADDR_W'(OFS_FLAGS);
  localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(OFS_MASK);

  logic              sel_flags, sel_mask;
  logic              rd_clr, mask_wr;
  logic [EVT_N-1:0]  evt_flags;
  logic              busy_flag;
  logic [FIFO_N-1:0] full_flags, empty_flags;
  logic [REG_W-1:0]  flags, mask;

  assign sel_flags = (bus_addr == A_FLAGS);
  assign sel_mask  = (bus_addr == A_MASK);
  assign rd_clr    = bus_rd & sel_flags;
  assign mask_wr   = bus_wr & sel_mask;

  sdc_evt_flags #(.EVT_N(EVT_N)) u_evt (
    .clk       (clk),
    .rst       (rst),
    .evt_pulse (evt_pulse),
    .card_busy (card_busy),
    .rd_clr    (rd_clr),
    .evt_flags (evt_flags),
    .busy_flag (busy_flag)
  );

  for (genvar f = 0; f < FIFO_N; f++) begin : g_fifo
    sdc_fifo_flags u_ff (
      .clk        (clk),
      .rst        (rst),
      .full_in    (fifo_full[f]),
      .empty_in   (fifo_empty[f]),
      .full_flag  (full_flags[f]),
      .empty_flag (empty_flags[f])
    );
  end

  assign flags = {busy_flag, evt_flags, full_flags, empty_flags};

  sdc_mask_reg #(.W(REG_W)) u_mask (
    .clk   (clk),
    .rst   (rst),
    .wr    (mask_wr),
    .wdata (bus_wdata),
    .mask  (mask)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      irq <= |(flags & ~mask);
      if (bus_rd) begin
        if (sel_flags)     bus_rdata <= flags;
        else if (sel_mask) bus_rdata <= mask;
        else               bus_rdata <= '0;
      end
    end
  end

  // R9
  irq_masked_chk: assert property (@(posedge clk) disable iff (rst)
    (&mask) |=> !irq);
  // R10
  flag_wr_ign_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && sel_flags && !bus_rd && evt_pulse == '0 && $stable(card_busy)
     && $stable(fifo_full) && $stable(fifo_empty)) |=> $stable(flags));
endmodule

// File: tb/sdc_irq_unit_test.sv
`timescale 1ns/1ps
module sdc_irq_unit_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] evt_pulse = '0;
  logic       card_busy = 1'b0;
  logic [1:0] fifo_full = 2'b00;
  logic [1:0] fifo_empty = 2'b11;
  logic [0:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  sdc_irq_unit uut (
    .clk(clk), .rst(rst), .evt_pulse(evt_pulse), .card_busy(card_busy),
    .fifo_full(fifo_full), .fifo_empty(fifo_empty), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  // {evt, busy, full, empty, rd, wr, addr, wdata, exp_rdata, chk_rd, exp_irq}
  // exp_irq is the value after the row's edge, taken from state before it
  localparam int NV = 25;
  localparam logic [28:0] VEC [NV] = '{
    {3'b000,1'b0,2'b00,2'b11,1'b0,1'b1,1'b1,8'h00,8'h00,1'b0,1'b0},
    {3'b000,1'b0,2'b00,2'b11,1'b1,1'b0,1'b0,8'h00,8'h03,1'b1,1'b1},
    {3'b000,1'b0,2'b00,2'b11,1'b1,1'b0,1'b0,8'h00,8'h03,1'b1,1'b1},
    {3'b000,1'b0,2'b00,2'b11,1'b0,1'b1,1'b1,8'h03,8'h00,1'b0,1'b1},
    {3'b100,1'b0,2'b00,2'b11,1'b0,1'b0,1'b0,8'h00,8'h00,1'b0,1'b0},
    {3'b000,1'b0,2'b00,2'b11,1'b1,1'b0,1'b0,8'h00,8'h43,1'b1,1'b1},
    {3'b000,1'b0,2'b00,2'b11,1'b1,1'b0,1'b0,8'h00,8'h03,1'b1,1'b0},
    {3'b011,1'b0,2'b00,2'b11,1'b1,1'b0,1'b0,8'h00,8'h03,1'b1,1'b0},
    {3'b000,1'b0,2'b00,2'b11,1'b1,1'b0,1'b0,8'h00,8'h33,1'b1,1'b1},
    {3'b000,1'b0,2'b01,2'b10,1'b0,1'b0,1'b0,8'h00,8'h00,1'b0,1'b0},
    {3'b000,1'b0,2'b01,2'b10,1'b1,1'b0,1'b0,8'h00,8'h06,1'b1,1'b1},
    {3'b000,1'b0,2'b00,2'b10,1'b1,1'b0,1'b0,8'h00,8'h06,1'b1,1'b1},
    {3'b000,1'b0,2'b00,2'b11,1'b0,1'b0,1'b0,8'h00,8'h00,1'b0,1'b1},
    {3'b000,1'b0,2'b00,2'b11,1'b1,1'b0,1'b0,8'h00,8'h03,1'b1,1'b0},
    {3'b000,1'b1,2'b00,2'b11,1'b0,1'b0,1'b0,8'h00,8'h00,1'b0,1'b0},
    {3'b000,1'b1,2'b00,2'b11,1'b1,1'b0,1'b0,8'h00,8'h83,1'b1,1'b1},
    {3'b000,1'b1,2'b00,2'b11,1'b1,1'b0,1'b0,8'h00,8'h03,1'b1,1'b0},
    {3'b000,1'b1,2'b00,2'b11,1'b0,1'b1,1'b1,8'hA5,8'h00,1'b0,1'b0},
    {3'b000,1'b1,2'b00,2'b11,1'b1,1'b0,1'b1,8'h00,8'hA5,1'b1,1'b1},
    {3'b000,1'b1,2'b00,2'b11,1'b0,1'b1,1'b0,8'hFF,8'h00,1'b0,1'b1},
    {3'b000,1'b1,2'b00,2'b11,1'b1,1'b0,1'b0,8'h00,8'h03,1'b1,1'b1},
    {3'b000,1'b1,2'b10,2'b01,1'b0,1'b0,1'b0,8'h00,8'h00,1'b0,1'b1},
    {3'b000,1'b1,2'b10,2'b01,1'b1,1'b0,1'b0,8'h00,8'h09,1'b1,1'b1},
    {3'b000,1'b1,2'b10,2'b01,1'b0,1'b1,1'b1,8'hFF,8'h00,1'b0,1'b1},
    {3'b000,1'b1,2'b10,2'b01,1'b0,1'b0,1'b0,8'h00,8'h00,1'b0,1'b0}
  };

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_idle();
    evt_pulse = '0;
    bus_rd = 1'b0;
    bus_wr = 1'b0;
    bus_addr = '0;
    bus_wdata = '0;
  endtask

  task automatic read_reg(input logic a, output logic [7:0] val);
    @(negedge clk);
    bus_idle();
    bus_rd = 1'b1;
    bus_addr = a;
    @(posedge clk);
    #1 val = bus_rdata;
    @(negedge clk);
    bus_idle();
  endtask

  task automatic write_reg(input logic a, input logic [7:0] d);
    @(negedge clk);
    bus_idle();
    bus_wr = 1'b1;
    bus_addr = a;
    bus_wdata = d;
    @(negedge clk);
    bus_idle();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R1 reset outputs
    check8("R1 rdata after reset", bus_rdata, 8'h00);
    check8("R1 irq after reset", {7'b0, irq}, 8'h00);
    read_reg(1'b1, v);
    check8("R1 mask reset value", v, 8'hFF);
    read_reg(1'b0, v);
    check8("R1 flag reset value", v, 8'h03);

    // table walk: R2 R3 R4 R5 R6 R7 R8 R9 R10
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {evt_pulse, card_busy, fifo_full, fifo_empty, bus_rd, bus_wr, bus_addr, bus_wdata} = VEC[i][28:10];
      @(posedge clk);
      #1;
      if (VEC[i][1])
        check8($sformatf("row %0d rdata (R2 R3 R4 R5 R6 R7 R8 R10)", i), bus_rdata, VEC[i][9:2]);
      check8($sformatf("row %0d irq (R9)", i), {7'b0, irq}, {7'b0, VEC[i][0]});
    end
    @(negedge clk);
    bus_idle();

    // R4 directed: pulse during read, next read still sees it
    @(negedge clk);
    evt_pulse = 3'b001;
    bus_rd = 1'b1;
    bus_addr = 1'b0;
    @(posedge clk);
    #1 v = bus_rdata;
    check8("R4 read with coincident frame pulse", v & 8'h10, 8'h00);
    read_reg(1'b0, v);
    check8("R4 frame bit kept for next read", v & 8'h10, 8'h10);

    // R8 mask read leaves flags untouched
    @(negedge clk);
    evt_pulse = 3'b010;
    @(negedge clk);
    bus_idle();
    read_reg(1'b1, v);
    check8("R8 mask readback", v, 8'hFF);
    read_reg(1'b0, v);
    check8("R8 flags survive mask read", v & 8'h20, 8'h20);

    // R1 reset in mid-run restores both registers
    write_reg(1'b1, 8'h00);
    @(negedge clk);
    rst = 1'b1;
    card_busy = 1'b0;
    fifo_full = 2'b00;
    fifo_empty = 2'b11;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    read_reg(1'b1, v);
    check8("R1 mask after second reset", v, 8'hFF);
    read_reg(1'b0, v);
    check8("R1 flags after second reset", v, 8'h03);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule